// File: doc/BRIEF.md
# GMII Frame Transmit Framer

This block turns a byte-wide packet stream with a valid/ready/last handshake into the byte-per-clock line signalling of a gigabit media-independent interface. Each line cycle carries a data byte, a data-valid flag and an error flag. Every frame opens with a fixed synchronisation pattern and a start delimiter. The payload follows at one byte per clock. The block then appends an Ethernet CRC-32 frame check sequence that it computes itself.

Payloads that are too short are filled with zero bytes up to a configurable minimum length before the check sequence. Payloads that are too long are cut at a configurable maximum. The bytes past the cut are still taken from the stream and still enter the CRC, so the check sequence reflects the full original payload. A receiver therefore sees a mismatch and can tell that the frame was cut.

The upstream source must offer payload bytes back to back once a frame has begun. If a byte is missing inside the payload window, the block sends 0x00 in its place, because the line cannot pause. The block is meant to sit between a packet source and the line interface of a gigabit transceiver.

Top module: `gmii_tx_framer`

## Requirements
- R1: A frame starts only when `in_valid` is high while the block is idle. It opens with seven line cycles of 0x55 and then one cycle of 0xD5, with `gm_dv` high throughout.
- R2: After the delimiter, each payload byte accepted by a handshake at a clock edge appears on `gm_data` with `gm_dv` high from that edge on, in arrival order, one byte per clock.
- R3: After the payload (and any fill), four check-sequence bytes follow with `gm_dv` high, least significant byte first. The value is the complement of a CRC-32 with reflected polynomial 0xEDB88320 and initial value 0xFFFFFFFF, taken over every byte that entered the frame.
- R4: After the last check-sequence byte, `gm_dv` stays low for at least one full cycle before the next 0x55 appears.
- R5: Whenever `gm_dv` is low, `gm_data` is 0x00.
- R6: A payload shorter than `MIN_LEN` bytes (default 60) is followed by zero bytes, with `gm_dv` high, until `MIN_LEN` bytes have been sent. These fill bytes are included in the CRC.
- R7: Only the first `MAX_LEN` payload bytes (default 9000) are sent. Each further byte is still accepted, one per cycle, and the line is idle (`gm_dv` low, data 0x00) during that cycle. The check sequence that follows covers the whole original payload.
- R8: `in_ready` is high only from the cycle after the delimiter is driven until the last payload byte is accepted. It is low while idle and during the preamble, fill, check sequence and gap.
- R9: `gm_er` is never asserted.
- R10: While and right after reset, `gm_dv`, `gm_data` and `in_ready` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Payload byte offered by the source |
| in_valid | input | 1 | `in_data` holds a byte |
| in_last | input | 1 | The offered byte ends the payload |
| in_ready | output | 1 | The block takes the offered byte at the next edge |
| gm_data | output | 8 | Line data byte |
| gm_dv | output | 1 | Line data-valid |
| gm_er | output | 1 | Line error flag, held low |

## Verification
The bound checker watches four things on every cycle: that idle cycles carry a zero byte, that the error line stays low, that the handshake window opens exactly when the delimiter is on the line, and that every byte accepted below the length cap reappears on the next cycle with data-valid high. Other behaviour depends on whole-frame context, and only the bench's scenarios can show it. That covers the exact preamble count, the minimum-length fill, the check-sequence value, the one-cycle gap between back-to-back frames, and the idle cycles and full-payload CRC of an oversize frame. The bench checks these by comparing the line against a behavioural model on every clock.

// File: rtl/gmii_fr_pkg.sv
package gmii_fr_pkg;

    localparam logic [7:0]  SYNC_BYTE   = 8'h55;
    localparam logic [7:0]  DELIM_BYTE  = 8'hD5;
    localparam logic [31:0] CRC_POLY_R  = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED    = 32'hFFFFFFFF;
    localparam int          SYNC_COUNT  = 7;
    localparam int          FCS_BYTES   = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_DELIM,
        ST_BODY,
        ST_FILL,
        ST_SKIP,
        ST_FCS,
        ST_GAP
    } fr_state_e;

    typedef struct packed {
        logic       dv;
        logic [7:0] data;
    } line_word_t;

    // One byte of reflected CRC-32, least significant bit first.
    function automatic logic [31:0] crc_advance(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            r = (r[0] ^ d[i]) ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
        end
        return r;
    endfunction

    // Byte k of the complemented remainder, lowest byte first.
    function automatic logic [7:0] fcs_pick(input logic [31:0] c, input logic [1:0] k);
        logic [31:0] f;
        f = ~c;
        return f[k*8 +: 8];
    endfunction

endpackage

// File: rtl/gmii_fr_crc.sv
module gmii_fr_crc
    import gmii_fr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        seed,
    input  logic        step,
    input  logic [7:0]  din,
    output logic [31:0] crc_q
);

    always_ff @(posedge clk) begin
        if (rst || seed) begin
            crc_q <= CRC_SEED;
        end else if (step) begin
            crc_q <= crc_advance(crc_q, din);
        end
    end

endmodule

// File: rtl/gmii_fr_ctrl.sv
module gmii_fr_ctrl
    import gmii_fr_pkg::*;
#(
    parameter int unsigned MAX_LEN = 9000,
    parameter int unsigned MIN_LEN = 60
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  in_data,
    input  logic        in_valid,
    input  logic        in_last,
    output logic        in_ready,
    input  logic [31:0] crc_q,
    output logic        crc_seed,
    output logic        crc_step,
    output logic [7:0]  crc_din,
    output line_word_t  nxt
);

    localparam int LW = $clog2(MAX_LEN + 1);
    localparam int PW = $clog2(SYNC_COUNT + 1);
    localparam logic [LW:0]   MAX_W     = (LW+1)'(MAX_LEN);
    localparam logic [LW:0]   MIN_W     = (LW+1)'(MIN_LEN);
    localparam logic [PW-1:0] SYNC_LAST = PW'(SYNC_COUNT - 1);
    localparam logic [1:0]    FCS_LAST  = 2'(FCS_BYTES - 1);

    fr_state_e     state_q, state_d;
    logic [LW-1:0] len_q, len_d;
    logic [PW-1:0] sync_q, sync_d;
    logic [1:0]    fcs_q, fcs_d;

    logic [LW:0]   len_inc;
    logic [7:0]    body_byte;
    logic          body_last;

    assign len_inc   = {1'b0, len_q} + 1'b1;
    assign body_byte = in_valid ? in_data : 8'h00;
    assign body_last = in_valid & in_last;
    assign in_ready  = (state_q == ST_BODY) || (state_q == ST_SKIP);

    always_comb begin
        state_d  = state_q;
        len_d    = len_q;
        sync_d   = sync_q;
        fcs_d    = fcs_q;
        nxt      = '0;
        crc_seed = 1'b0;
        crc_step = 1'b0;
        crc_din  = 8'h00;

        case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    nxt.dv   = 1'b1;
                    nxt.data = SYNC_BYTE;
                    crc_seed = 1'b1;
                    len_d    = '0;
                    sync_d   = PW'(1);
                    state_d  = ST_SYNC;
                end
            end
            ST_SYNC: begin
                nxt.dv   = 1'b1;
                nxt.data = SYNC_BYTE;
                sync_d   = sync_q + 1'b1;
                if (sync_q == SYNC_LAST) begin
                    state_d = ST_DELIM;
                end
            end
            ST_DELIM: begin
                nxt.dv   = 1'b1;
                nxt.data = DELIM_BYTE;
                state_d  = ST_BODY;
            end
            ST_BODY: begin
                crc_step = 1'b1;
                crc_din  = body_byte;
                fcs_d    = '0;
                if ({1'b0, len_q} < MAX_W) begin
                    nxt.dv   = 1'b1;
                    nxt.data = body_byte;
                    len_d    = len_inc[LW-1:0];
                    if (body_last) begin
                        state_d = (len_inc < MIN_W) ? ST_FILL : ST_FCS;
                    end
                end else begin
                    state_d = body_last ? ST_FCS : ST_SKIP;
                end
            end
            ST_SKIP: begin
                fcs_d = '0;
                if (in_valid) begin
                    crc_step = 1'b1;
                    crc_din  = in_data;
                    if (in_last) begin
                        state_d = ST_FCS;
                    end
                end
            end
            ST_FILL: begin
                nxt.dv   = 1'b1;
                nxt.data = 8'h00;
                crc_step = 1'b1;
                crc_din  = 8'h00;
                len_d    = len_inc[LW-1:0];
                if (len_inc >= MIN_W) begin
                    state_d = ST_FCS;
                end
            end
            ST_FCS: begin
                nxt.dv   = 1'b1;
                nxt.data = fcs_pick(crc_q, fcs_q);
                fcs_d    = fcs_q + 1'b1;
                if (fcs_q == FCS_LAST) begin
                    state_d = ST_GAP;
                end
            end
            ST_GAP: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            len_q   <= '0;
            sync_q  <= '0;
            fcs_q   <= '0;
        end else begin
            state_q <= state_d;
            len_q   <= len_d;
            sync_q  <= sync_d;
            fcs_q   <= fcs_d;
        end
    end

endmodule

// File: rtl/gmii_fr_drive.sv
module gmii_fr_drive
    import gmii_fr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  line_word_t nxt,
    output logic [7:0] gm_data,
    output logic       gm_dv,
    output logic       gm_er
);

    always_ff @(posedge clk) begin
        if (rst) begin
            gm_dv   <= 1'b0;
            gm_data <= 8'h00;
        end else begin
            gm_dv   <= nxt.dv;
            gm_data <= nxt.dv ? nxt.data : 8'h00;
        end
    end

    assign gm_er = 1'b0;

endmodule

// File: rtl/gmii_tx_framer.sv
module gmii_tx_framer
    import gmii_fr_pkg::*;
#(
    parameter int unsigned MAX_LEN = 9000,
    parameter int unsigned MIN_LEN = 60
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_last,
    output logic       in_ready,
    output logic [7:0] gm_data,
    output logic       gm_dv,
    output logic       gm_er
);

    logic        crc_seed;
    logic        crc_step;
    logic [7:0]  crc_din;
    logic [31:0] crc_q;
    line_word_t  nxt;

    gmii_fr_ctrl #(
        .MAX_LEN (MAX_LEN),
        .MIN_LEN (MIN_LEN)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_last  (in_last),
        .in_ready (in_ready),
        .crc_q    (crc_q),
        .crc_seed (crc_seed),
        .crc_step (crc_step),
        .crc_din  (crc_din),
        .nxt      (nxt)
    );

    gmii_fr_crc u_crc (
        .clk   (clk),
        .rst   (rst),
        .seed  (crc_seed),
        .step  (crc_step),
        .din   (crc_din),
        .crc_q (crc_q)
    );

    gmii_fr_drive u_drive (
        .clk     (clk),
        .rst     (rst),
        .nxt     (nxt),
        .gm_data (gm_data),
        .gm_dv   (gm_dv),
        .gm_er   (gm_er)
    );

endmodule

// File: rtl/gmii_tx_framer_chk.sv
module gmii_tx_framer_chk #(
    parameter int unsigned MAX_LEN = 9000
) (
    input logic       clk,
    input logic       rst,
    input logic [7:0] in_data,
    input logic       in_valid,
    input logic       in_ready,
    input logic [7:0] gm_data,
    input logic       gm_dv,
    input logic       gm_er
);

    int unsigned acc_q;

    always_ff @(posedge clk) begin
        if (rst || !in_ready) begin
            acc_q <= 0;
        end else if (acc_q < MAX_LEN) begin
            acc_q <= acc_q + 1;
        end
    end

    // R5
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !gm_dv |-> gm_data == 8'h00);

    // R9
    no_error_chk: assert property (@(posedge clk) disable iff (rst)
        !gm_er);

    // R1
    window_after_delim_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(in_ready) |-> gm_dv && gm_data == 8'hD5);

    // R2
    byte_forward_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready && acc_q < MAX_LEN |=> gm_dv && gm_data == $past(in_valid ? in_data : 8'h00));

    // R8
    ready_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready && acc_q < MAX_LEN |-> gm_dv);

endmodule

bind gmii_tx_framer gmii_tx_framer_chk #(.MAX_LEN(MAX_LEN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .gm_data  (gm_data),
    .gm_dv    (gm_dv),
    .gm_er    (gm_er)
);

// File: tb/tb_gmii_tx_framer.sv
`timescale 1ns/1ps
module tb_gmii_tx_framer;

    localparam int MAXL = 72;
    localparam int MINL = 60;

    localparam int T_SYNC  = 0;
    localparam int T_DELIM = 1;
    localparam int T_DATA  = 2;
    localparam int T_FILL  = 3;
    localparam int T_SKIP  = 4;
    localparam int T_FCS   = 5;
    localparam int T_GAP   = 6;
    localparam int T_IDLE  = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic [7:0] gm_data;
    logic       gm_dv;
    logic       gm_er;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    typedef struct {
        logic       dv;
        logic [7:0] d;
        int         tag;
    } exp_t;

    exp_t       expq[$];
    logic [7:0] pay[$];
    logic [7:0] crcbuf[$];

    always #2.5 clk = ~clk;

    gmii_tx_framer #(.MAX_LEN(MAXL), .MIN_LEN(MINL)) dut (
        .clk      (clk),
        .rst      (rst),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_last  (in_last),
        .in_ready (in_ready),
        .gm_data  (gm_data),
        .gm_dv    (gm_dv),
        .gm_er    (gm_er)
    );

    function automatic string req_of(int tag);
        case (tag)
            T_SYNC, T_DELIM: return "R1";
            T_DATA:          return "R2";
            T_FCS:           return "R3";
            T_GAP:           return "R4";
            T_FILL:          return "R6";
            T_SKIP:          return "R7";
            default:         return "R5";
        endcase
    endfunction

    function automatic logic [31:0] ref_fcs();
        logic [31:0] c;
        c = 32'hFFFFFFFF;
        foreach (crcbuf[i]) begin
            for (int k = 0; k < 8; k++) begin
                if (c[0] ^ crcbuf[i][k]) c = (c >> 1) ^ 32'hEDB88320;
                else c = c >> 1;
            end
        end
        return ~c;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic bus_check();
        exp_t e;
        if (expq.size() > 0) e = expq.pop_front();
        else e = '{dv: 1'b0, d: 8'h00, tag: T_IDLE};
        check(gm_dv === e.dv, req_of(e.tag), "data-valid", int'(gm_dv), int'(e.dv));
        check(gm_data === e.d, req_of(e.tag), "data byte", int'(gm_data), int'(e.d));
        check(gm_er === 1'b0, "R9", "error line", int'(gm_er), 0);
        if (e.tag == T_SYNC || e.tag == T_FILL || e.tag == T_FCS ||
            e.tag == T_GAP || e.tag == T_IDLE)
            check(in_ready === 1'b0, "R8", "ready outside payload", int'(in_ready), 0);
        if (e.tag == T_DELIM)
            check(in_ready === 1'b1, "R8", "ready after delimiter", int'(in_ready), 1);
    endtask

    task automatic tick();
        @(negedge clk);
        bus_check();
    endtask

    task automatic push(logic dv, logic [7:0] d, int tag);
        expq.push_back('{dv: dv, d: d, tag: tag});
    endtask

    task automatic build(int len, int seed);
        logic [31:0] f;
        int sent;
        pay.delete();
        crcbuf.delete();
        for (int i = 0; i < len; i++) pay.push_back(8'((seed * 37) + (i * 13) + (i >> 3)));
        for (int i = 0; i < 7; i++) push(1'b1, 8'h55, T_SYNC);
        push(1'b1, 8'hD5, T_DELIM);
        sent = (len < MAXL) ? len : MAXL;
        for (int i = 0; i < sent; i++) push(1'b1, pay[i], T_DATA);
        for (int i = sent; i < len; i++) push(1'b0, 8'h00, T_SKIP);
        foreach (pay[i]) crcbuf.push_back(pay[i]);
        for (int i = len; i < MINL; i++) begin
            push(1'b1, 8'h00, T_FILL);
            crcbuf.push_back(8'h00);
        end
        f = ref_fcs();
        for (int i = 0; i < 4; i++) push(1'b1, f[i*8 +: 8], T_FCS);
        push(1'b0, 8'h00, T_GAP);
    endtask

    task automatic send_frame(int len, int seed, int pause);
        int idx;
        bit hs;
        for (int k = 0; k < pause; k++) tick();
        build(len, seed);
        idx = 0;
        in_valid = 1'b1;
        in_data  = pay[0];
        in_last  = (len == 1);
        forever begin
            hs = in_ready && in_valid;
            tick();
            if (hs) begin
                idx++;
                if (idx == len) break;
                in_data = pay[idx];
                in_last = (idx == len - 1);
            end
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_data  = 8'h00;
        check(idx == len, "R8", "accepted byte count", idx, len);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        // R10: state while reset is held
        repeat (3) @(negedge clk);
        check(gm_dv === 1'b0, "R10", "reset dv", int'(gm_dv), 0);
        check(gm_data === 8'h00, "R10", "reset data", int'(gm_data), 0);
        check(in_ready === 1'b0, "R10", "reset ready", int'(in_ready), 0);
        rst = 1'b0;
        repeat (3) tick();                 // R5 idle line
        send_frame(1, 1, 0);               // R6 heavy fill
        send_frame(59, 2, 0);              // R6 one fill byte, back to back (R4)
        send_frame(60, 3, 0);              // exactly minimum
        send_frame(61, 4, 2);              // above minimum after a pause
        send_frame(MAXL, 5, 0);            // exactly maximum
        send_frame(MAXL + 1, 6, 0);        // R7 one excess byte
        send_frame(100, 7, 0);             // R7 many excess bytes
        send_frame(64, 8, 5);              // R2 normal frame after truncation
        while (expq.size() > 0) tick();
        repeat (4) tick();                 // R5 idle after traffic
        finish_run();
    end

endmodule